// File: doc/BRIEF.md
# 16K Bank Cartridge Address Decoder

This block turns a CPU bus address into chip selects and upper address lines for a cartridge that carries a flash device and an SRAM. Banks are 16K wide. A bank is split into a low 8K half and a high 8K half. The halves appear at `$8000-$9FFF` and `$A000-$BFFF`. The I/O page `$DE00-$DFFF` opens a 512-byte window onto the top 512 bytes of the low half of the current bank. While the machine is frozen, the map changes. RAM always sits in the low window, the high half moves up to `$E000-$FFFF`, and the I/O page either shows flash or nothing.

The configuration bits come from a register file outside this block. They are the RAM-select bit, the mixed/all-RAM bit, the freeze state, the bank number, the bank lock, the register enables and the flash write permissions. The block captures them in one mode register on each clock. The address decode itself is purely combinational. A register file next to this block answers the CPU whenever `reg_hit` is high, and no memory device is selected on those cycles.

Top module: `bank16_decoder`

## Requirements
- R1: While reset is low, the mode register clears to all zeros, whatever the cfg inputs are. On the first cycle after reset, `$8000` therefore selects flash at memory address `0x00000`.
- R2: A change on a cfg input affects the outputs only after the next rising clock edge. A change of `cpu_addr` or `cpu_wr` affects the outputs in the same cycle, with no clock edge in between.
- R3: Outside freeze with the RAM bit at 0, `$8000-$9FFF` and `$A000-$BFFF` select flash. Memory address bit 13 is 0 for the low window and 1 for the high window. Bits 18..14 come from `cfg_bank[5:1]`. `cfg_bank[0]` is ignored. Bits 12..0 equal `cpu_addr[12:0]`.
- R4: Outside freeze with the RAM bit at 1 and the all-RAM bit at 0, the low window selects SRAM and the high window selects flash.
- R5: Outside freeze with the RAM bit at 1 and the all-RAM bit at 1, both windows select SRAM.
- R6: Outside freeze, an I/O page address that is not a claimed register maps to the low half of the bank. The memory offset is `0x1E00 + cpu_addr[8:0]`. The device is SRAM if the RAM bit is 1 and flash otherwise.
- R7: In freeze, `$8000-$9FFF` always selects the SRAM low half, and `$A000-$BFFF` selects nothing.
- R8: In freeze, `$E000-$FFFF` selects the high half: SRAM when the all-RAM bit is 0, flash when it is 1. Outside freeze this range selects nothing.
- R9: In freeze, the I/O page selects the flash mirror of R6 when the RAM bit is 0 and nothing when it is 1.
- R10: With the bank lock set, memory address bits 15..14 are forced to 0. Bits 18..16 are kept.
- R11: When `cfg_ctl_en` is 1, `$DE00` and `$DE01` raise `reg_hit`. When `cfg_regs_en` is 1, `$DF10-$DF13` raise `reg_hit`. Either way, no chip select is asserted on those addresses. When the enable is 0, the address falls through to the memory map.
- R12: `flash_we` is 1 only when all of these hold: flash is selected, `cpu_wr` is 1, flash writes are enabled, and the ROM lock is clear.
- R13: At most one chip select is high. All other addresses (`$0000-$7FFF`, `$C000-$DDFF`) select nothing. `mem_addr` reads 0 whenever no chip is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ram_sel | input | 1 | RAM-select bit (1 = RAM in the banked windows) |
| cfg_all_ram | input | 1 | 0 = mixed layout, 1 = all-RAM layout |
| cfg_freeze | input | 1 | Freeze state |
| cfg_bank_lock | input | 1 | 1 = clear bank bits 15..14 |
| cfg_ctl_en | input | 1 | Claim `$DE00/$DE01` as registers |
| cfg_regs_en | input | 1 | Claim `$DF10-$DF13` as registers |
| cfg_fl_wr_en | input | 1 | Flash writes enabled |
| cfg_rom_lock | input | 1 | Flash write lock |
| cfg_bank | input | 6 | Bank number, bit i = memory address bit 13+i |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | 1 = write cycle |
| flash_cs | output | 1 | Flash chip select |
| sram_cs | output | 1 | SRAM chip select |
| flash_we | output | 1 | Flash write strobe |
| reg_hit | output | 1 | Address is a claimed register |
| mem_addr | output | 19 | Memory address for the selected device |

## Verification
A corrupted mode bit shows up on the very next bus address that falls in a window governed by that bit. The symptom is the wrong chip select, a select appearing where none belongs, or a missing select. A corrupted bank bit shows up only as a wrong value in `mem_addr[18:14]`, and only while a chip is selected. Because the decode is combinational, each error appears in the same cycle as the address that exposes it. The mode register adds exactly one cycle of latency. A reference model that updates its own copy of the mode at each clock edge therefore catches a lost or extra register stage at the first configuration change.

// File: rtl/bank16_pkg.sv
// bank16_pkg: shared types for the 16K bank decoder.
// Assumes: 16-bit CPU address, I/O page at $DE00-$DFFF.
package bank16_pkg;

    // Address region classes produced by the window decoder
    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_LO   = 3'd1,
        WIN_HI   = 3'd2,
        WIN_IO   = 3'd3,
        WIN_TOP  = 3'd4,
        WIN_REG  = 3'd5
    } win_e;

    // Device targeted by an access
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_SRAM  = 2'd2
    } tgt_e;

    // Captured single-bit mode flags
    typedef struct packed {
        logic ram_sel;
        logic all_ram;
        logic freeze;
        logic bank_lock;
        logic ctl_en;
        logic regs_en;
        logic fl_wr_en;
        logic rom_lock;
    } mode_t;

    localparam logic [2:0]  SEG_LO   = 3'b100;        // $8000-$9FFF
    localparam logic [2:0]  SEG_HI   = 3'b101;        // $A000-$BFFF
    localparam logic [2:0]  SEG_TOP  = 3'b111;        // $E000-$FFFF
    localparam logic [6:0]  IO_PAGE  = 7'b1101111;    // $DE00-$DFFF
    localparam logic [14:0] CTL_PAIR = 15'h6F00;      // $DE00/$DE01
    localparam logic [13:0] MMC_QUAD = 14'h37C4;      // $DF10-$DF13
    localparam logic [3:0]  MIRROR_HI = 4'hF;         // offset $1E00 in a half

endpackage

// File: rtl/bank16_mode_reg.sv
// bank16_mode_reg: captures the mode flags and the bank bits above A13
// once per clock. Assumes the sources are synchronous to clk.
module bank16_mode_reg #(
    parameter int BANK_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  bank16_pkg::mode_t        mode_d,
    input  logic [BANK_W-2:0]        bank_d,
    output bank16_pkg::mode_t        mode_q,
    output logic [BANK_W-2:0]        bank_q
);
    // Capture configuration, clearing it on synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            bank_q <= '0;
        end else begin
            mode_q <= mode_d;
            bank_q <= bank_d;
        end
    end
endmodule

// File: rtl/bank16_win_dec.sv
// bank16_win_dec: classifies a CPU address into a region. Enabled
// register addresses win over the I/O page window. Purely combinational.
module bank16_win_dec (
    input  logic [15:0]         addr,
    input  logic                ctl_en,
    input  logic                regs_en,
    output bank16_pkg::win_e    win
);
    import bank16_pkg::*;

    logic ctl_hit;
    logic mmc_hit;

    // Detect claimed register addresses
    always_comb begin
        ctl_hit = ctl_en  && (addr[15:1] == CTL_PAIR);
        mmc_hit = regs_en && (addr[15:2] == MMC_QUAD);
    end

    // Pick the region, registers first
    always_comb begin
        if (ctl_hit || mmc_hit)            win = WIN_REG;
        else if (addr[15:9] == IO_PAGE)    win = WIN_IO;
        else if (addr[15:13] == SEG_LO)    win = WIN_LO;
        else if (addr[15:13] == SEG_HI)    win = WIN_HI;
        else if (addr[15:13] == SEG_TOP)   win = WIN_TOP;
        else                               win = WIN_NONE;
    end
endmodule

// File: rtl/bank16_route.sv
// bank16_route: chooses the device, the bank half and the mirror flag for
// a region, from the RAM bit, the layout bit and the freeze state.
module bank16_route (
    input  bank16_pkg::win_e    win,
    input  logic                ram_sel,
    input  logic                all_ram,
    input  logic                freeze,
    output bank16_pkg::tgt_e    tgt,
    output logic                half,
    output logic                mirror
);
    import bank16_pkg::*;

    // Region-to-device table for normal and freeze maps
    always_comb begin
        tgt    = TGT_NONE;
        half   = 1'b0;
        mirror = 1'b0;
        unique case (win)
            WIN_LO: begin
                tgt = (freeze || ram_sel) ? TGT_SRAM : TGT_FLASH;
            end
            WIN_HI: begin
                half = 1'b1;
                if (!freeze)
                    tgt = (ram_sel && all_ram) ? TGT_SRAM : TGT_FLASH;
            end
            WIN_IO: begin
                mirror = 1'b1;
                if (freeze)
                    tgt = ram_sel ? TGT_NONE : TGT_FLASH;
                else
                    tgt = ram_sel ? TGT_SRAM : TGT_FLASH;
            end
            WIN_TOP: begin
                half = 1'b1;
                if (freeze)
                    tgt = all_ram ? TGT_FLASH : TGT_SRAM;
            end
            default: tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/bank16_addr_form.sv
// bank16_addr_form: builds the memory address from the bank bits above
// A13, the half select and the in-half offset. The lock clears the lowest
// LOCK_N bank bits. Drives zero when no device is selected.
module bank16_addr_form #(
    parameter int BANK_W = 6,
    parameter int LOCK_N = 2,
    parameter int MEM_AW = 13 + BANK_W
) (
    input  logic [BANK_W-2:0]   bank_hi,
    input  logic                lock,
    input  logic                active,
    input  logic                half,
    input  logic                mirror,
    input  logic [12:0]         off,
    output logic [MEM_AW-1:0]   mem_addr
);
    import bank16_pkg::*;

    logic [BANK_W-2:0] bank_eff;
    logic [12:0]       off_eff;

    // Mask the locked bank bits, pass the rest through
    for (genvar gi = 0; gi < BANK_W - 1; gi++) begin : g_bank
        if (gi < LOCK_N) begin : g_lockable
            assign bank_eff[gi] = bank_hi[gi] & ~lock;
        end else begin : g_free
            assign bank_eff[gi] = bank_hi[gi];
        end
    end

    // Select the mirrored 512-byte offset for the I/O page
    always_comb begin
        off_eff = mirror ? {MIRROR_HI, off[8:0]} : off;
    end

    // Assemble the final address or park it at zero
    always_comb begin
        mem_addr = active ? {bank_eff, half, off_eff} : '0;
    end
endmodule

// File: rtl/bank16_decoder.sv
// bank16_decoder: top of the 16K bank address decoder. Registers the
// mode inputs, then decodes the CPU address combinationally into chip
// selects, the flash write strobe, a register hit and the memory address.
// Assumes cpu_addr/cpu_wr are valid for the whole bus cycle.
module bank16_decoder #(
    parameter int BANK_W = 6,
    parameter int LOCK_N = 2,
    parameter int MEM_AW = 13 + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ram_sel,
    input  logic              cfg_all_ram,
    input  logic              cfg_freeze,
    input  logic              cfg_bank_lock,
    input  logic              cfg_ctl_en,
    input  logic              cfg_regs_en,
    input  logic              cfg_fl_wr_en,
    input  logic              cfg_rom_lock,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_wr,
    output logic              flash_cs,
    output logic              sram_cs,
    output logic              flash_we,
    output logic              reg_hit,
    output logic [MEM_AW-1:0] mem_addr
);
    import bank16_pkg::*;

    mode_t             mode_d;
    mode_t             mode_q;
    logic [BANK_W-2:0] bank_q;
    logic              unused_a13;
    win_e              win;
    tgt_e              tgt;
    logic              half;
    logic              mirror;

    // Gather the flag inputs; bank bit A13 plays no part in 16K banking
    always_comb begin
        mode_d = '{ram_sel:   cfg_ram_sel,   all_ram:  cfg_all_ram,
                   freeze:    cfg_freeze,    bank_lock: cfg_bank_lock,
                   ctl_en:    cfg_ctl_en,    regs_en:  cfg_regs_en,
                   fl_wr_en:  cfg_fl_wr_en,  rom_lock: cfg_rom_lock};
    end
    assign unused_a13 = cfg_bank[0];

    bank16_mode_reg #(.BANK_W(BANK_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_d (mode_d),
        .bank_d (cfg_bank[BANK_W-1:1]),
        .mode_q (mode_q),
        .bank_q (bank_q)
    );

    bank16_win_dec u_win (
        .addr    (cpu_addr),
        .ctl_en  (mode_q.ctl_en),
        .regs_en (mode_q.regs_en),
        .win     (win)
    );

    bank16_route u_route (
        .win     (win),
        .ram_sel (mode_q.ram_sel),
        .all_ram (mode_q.all_ram),
        .freeze  (mode_q.freeze),
        .tgt     (tgt),
        .half    (half),
        .mirror  (mirror)
    );

    bank16_addr_form #(.BANK_W(BANK_W), .LOCK_N(LOCK_N), .MEM_AW(MEM_AW)) u_addr (
        .bank_hi  (bank_q),
        .lock     (mode_q.bank_lock),
        .active   (tgt != TGT_NONE),
        .half     (half),
        .mirror   (mirror),
        .off      (cpu_addr[12:0]),
        .mem_addr (mem_addr)
    );

    // Drive the device strobes from the routed target
    always_comb begin
        flash_cs = (tgt == TGT_FLASH);
        sram_cs  = (tgt == TGT_SRAM);
        reg_hit  = (win == WIN_REG);
        flash_we = flash_cs && cpu_wr && mode_q.fl_wr_en && !mode_q.rom_lock;
    end
endmodule

// File: rtl/bank16_chk.sv
// bank16_chk: protocol checks on the decoder's ports, bound to every
// instance of bank16_decoder. Mode-dependent checks look one cycle back
// at the cfg inputs, because the mode register delays them by one cycle.
module bank16_chk #(
    parameter int MEM_AW = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_freeze,
    input logic              cfg_bank_lock,
    input logic [15:0]       cpu_addr,
    input logic              cpu_wr,
    input logic              flash_cs,
    input logic              sram_cs,
    input logic              flash_we,
    input logic              reg_hit,
    input logic [MEM_AW-1:0] mem_addr
);
    // R13: the two chip selects never overlap
    p_one_cs_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_cs && sram_cs));

    // R13: the address is parked at zero when idle
    p_idle_addr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_cs && !sram_cs) |-> (mem_addr == '0));

    // R11: a register hit excludes both memories
    p_reg_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hit |-> (!flash_cs && !sram_cs));

    // R12: the write strobe needs a selected flash and a write cycle
    p_we_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flash_we |-> (flash_cs && cpu_wr));

    // R3: the low window always uses the low half
    p_lo_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_addr[15:13] == 3'b100) && (flash_cs || sram_cs)) |-> !mem_addr[13]);

    // R7: frozen low window is RAM
    p_frz_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_freeze) && cpu_addr[15:13] == 3'b100) |-> sram_cs);

    // R8: the top range is empty outside freeze
    p_top_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_freeze) && cpu_addr[15:13] == 3'b111)
            |-> (!flash_cs && !sram_cs));

    // R10: the lock clears bank bits 15..14
    p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_bank_lock) && (flash_cs || sram_cs))
            |-> (mem_addr[15:14] == 2'b00));
endmodule

bind bank16_decoder bank16_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_freeze    (cfg_freeze),
    .cfg_bank_lock (cfg_bank_lock),
    .cpu_addr      (cpu_addr),
    .cpu_wr        (cpu_wr),
    .flash_cs      (flash_cs),
    .sram_cs       (sram_cs),
    .flash_we      (flash_we),
    .reg_hit       (reg_hit),
    .mem_addr      (mem_addr)
);

// File: tb/sim_bank16_decoder.sv
// sim_bank16_decoder: bench with a behavioural reference model, compared
// every clock. Inputs change 2 ns after a rising edge; outputs are sampled
// 2 ns after the next rising edge.
module sim_bank16_decoder;
    localparam int CLK_NS = 8;
    localparam int MEM_AW = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ram_sel = 0, cfg_all_ram = 0, cfg_freeze = 0, cfg_bank_lock = 0;
    logic cfg_ctl_en = 0, cfg_regs_en = 0, cfg_fl_wr_en = 0, cfg_rom_lock = 0;
    logic [5:0]  cfg_bank = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        flash_cs, sram_cs, flash_we, reg_hit;
    logic [MEM_AW-1:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model's copy of the mode as applied by the design
    bit m_ram, m_all, m_frz, m_lock, m_ctl, m_regs, m_fwe, m_rlk;
    int m_bank;

    always #(CLK_NS/2) clk = ~clk;

    bank16_decoder u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_ram_sel(cfg_ram_sel), .cfg_all_ram(cfg_all_ram),
        .cfg_freeze(cfg_freeze), .cfg_bank_lock(cfg_bank_lock),
        .cfg_ctl_en(cfg_ctl_en), .cfg_regs_en(cfg_regs_en),
        .cfg_fl_wr_en(cfg_fl_wr_en), .cfg_rom_lock(cfg_rom_lock),
        .cfg_bank(cfg_bank), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .flash_cs(flash_cs), .sram_cs(sram_cs), .flash_we(flash_we),
        .reg_hit(reg_hit), .mem_addr(mem_addr)
    );

    // Expected {reg_hit, flash_cs, sram_cs, flash_we, mem_addr}
    function automatic logic [MEM_AW+3:0] model(input int a, input bit wr);
        int dev = 0;            // 0 none, 1 flash, 2 sram
        int half = 0;
        int off = a % 8192;
        int b = m_bank / 2;
        bit rh = 0;
        int ma;
        if ((m_ctl && (a == 'hDE00 || a == 'hDE01)) ||
            (m_regs && a >= 'hDF10 && a <= 'hDF13)) rh = 1;
        else if (a >= 'hDE00 && a <= 'hDFFF) begin
            off = 'h1E00 + (a % 512);
            if (m_frz) dev = m_ram ? 0 : 1;
            else       dev = m_ram ? 2 : 1;
        end else if (a >= 'h8000 && a <= 'h9FFF) begin
            dev = (m_frz || m_ram) ? 2 : 1;
        end else if (a >= 'hA000 && a <= 'hBFFF) begin
            half = 1;
            if (!m_frz) dev = (m_ram && m_all) ? 2 : 1;
        end else if (a >= 'hE000) begin
            half = 1;
            if (m_frz) dev = m_all ? 1 : 2;
        end
        if (m_lock) b = b - (b % 4);
        ma = (dev == 0) ? 0 : b * 16384 + half * 8192 + off;
        return {rh, dev == 1, dev == 2, (dev == 1) && wr && m_fwe && !m_rlk,
                MEM_AW'(ma)};
    endfunction

    task automatic chk(input string tag, input logic [MEM_AW+3:0] got,
                       input logic [MEM_AW+3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, cpu_addr, got, exp);
        end
    endtask

    function automatic string tag_of(input int a);
        if ((m_ctl && (a == 'hDE00 || a == 'hDE01)) ||
            (m_regs && a >= 'hDF10 && a <= 'hDF13)) return "R11";
        if (a >= 'hDE00 && a <= 'hDFFF) return m_frz ? "R9" : "R6";
        if (a >= 'h8000 && a <= 'hBFFF) begin
            if (m_frz) return "R7";
            if (!m_ram) return "R3";
            return m_all ? "R5" : "R4";
        end
        if (a >= 'hE000) return "R8";
        return "R13";
    endfunction

    function automatic logic [MEM_AW+3:0] got_v();
        return {reg_hit, flash_cs, sram_cs, flash_we, mem_addr};
    endfunction

    // One clock: model follows the register, then compare
    task automatic cyc();
        @(posedge clk);
        if (!rst_n) begin
            {m_ram, m_all, m_frz, m_lock, m_ctl, m_regs, m_fwe, m_rlk} = '0;
            m_bank = 0;
        end else begin
            {m_ram, m_all, m_frz, m_lock} =
                {cfg_ram_sel, cfg_all_ram, cfg_freeze, cfg_bank_lock};
            {m_ctl, m_regs, m_fwe, m_rlk} =
                {cfg_ctl_en, cfg_regs_en, cfg_fl_wr_en, cfg_rom_lock};
            m_bank = int'(cfg_bank);
        end
        #2;
        chk(tag_of(int'(cpu_addr)), got_v(), model(int'(cpu_addr), cpu_wr));
    endtask

    task automatic set_mode(input bit ram, input bit all, input bit frz,
                            input bit lock, input bit ctl, input bit regs);
        {cfg_ram_sel, cfg_all_ram, cfg_freeze, cfg_bank_lock} = {ram, all, frz, lock};
        {cfg_ctl_en, cfg_regs_en} = {ctl, regs};
        cyc();
    endtask

    localparam int NADDR = 21;
    localparam int ADDRS [NADDR] = '{'h0000, 'h7FFF, 'h8000, 'h9ABC, 'h9FFF,
        'hA000, 'hB123, 'hBFFF, 'hC000, 'hDDFF, 'hDE00, 'hDE01, 'hDE02,
        'hDF0F, 'hDF10, 'hDF13, 'hDF14, 'hDFFF, 'hE000, 'hF456, 'hFFFF};

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset clears the mode even with every cfg input high
        {cfg_ram_sel, cfg_all_ram, cfg_freeze, cfg_bank_lock} = 4'hF;
        {cfg_ctl_en, cfg_regs_en, cfg_fl_wr_en, cfg_rom_lock} = 4'hF;
        cfg_bank = 6'h3F;
        cpu_addr = 16'h8000;
        cyc(); cyc();
        chk("R1", got_v(), {1'b0, 1'b1, 1'b0, 1'b0, 19'h00000});
        rst_n = 1'b1;
        {cfg_ram_sel, cfg_all_ram, cfg_freeze, cfg_bank_lock} = 4'h0;
        {cfg_ctl_en, cfg_regs_en, cfg_fl_wr_en, cfg_rom_lock} = 4'h0;
        cfg_bank = 6'h00;
        cyc();

        // R2: cfg change waits for an edge, address change does not
        cfg_ram_sel = 1'b1;
        #1;
        chk("R2", {7'b0, flash_cs, sram_cs}, 9'b0_0000_0010);
        cyc();
        chk("R2", {7'b0, flash_cs, sram_cs}, 9'b0_0000_0001);
        cpu_addr = 16'h0100;
        #1;
        chk("R2", {7'b0, flash_cs, sram_cs}, 9'b0);
        cfg_ram_sel = 1'b0;
        cyc();

        // R3: hand-computed bank address, A13 input ignored
        cfg_bank = 6'h3F; cpu_addr = 16'hA123;
        cyc();
        chk("R3", got_v(), {4'b0100, 19'h7E123});
        cfg_bank = 6'h3E;
        cyc();
        chk("R3", got_v(), {4'b0100, 19'h7E123});

        // R10: lock clears bits 15..14 and keeps 18..16
        cfg_bank_lock = 1'b1;
        cyc();
        chk("R10", got_v(), {4'b0100, 19'h72123});
        cfg_bank_lock = 1'b0;

        // R6: I/O page mirror offset, bank 0
        cfg_bank = 6'h00; cpu_addr = 16'hDF45;
        cyc();
        chk("R6", got_v(), {4'b0100, 19'h01F45});

        // R12: write strobe gating
        cpu_addr = 16'h8010; cpu_wr = 1'b1; cfg_fl_wr_en = 1'b1;
        cyc();
        chk("R12", {8'b0, flash_we}, 9'd1);
        cfg_rom_lock = 1'b1;
        cyc();
        chk("R12", {8'b0, flash_we}, 9'd0);
        cfg_rom_lock = 1'b0; cfg_ram_sel = 1'b1;
        cyc();
        chk("R12", {8'b0, flash_we}, 9'd0);
        cfg_ram_sel = 1'b0; cpu_wr = 1'b0;
        cyc();

        // Sweep every layout over the address list
        cfg_bank = 6'h2D;
        for (int m = 0; m < 64; m++) begin
            set_mode(m[0], m[1], m[2], m[3], m[4], m[5]);
            for (int k = 0; k < NADDR; k++) begin
                cpu_addr = 16'(ADDRS[k]);
                cpu_wr = k[0];
                cfg_fl_wr_en = k[1];
                cyc();
            end
        end

        // Random traffic, cfg and address changing together
        for (int n = 0; n < 600; n++) begin
            {cfg_ram_sel, cfg_all_ram, cfg_freeze, cfg_bank_lock} = 4'($urandom);
            {cfg_ctl_en, cfg_regs_en, cfg_fl_wr_en, cfg_rom_lock} = 4'($urandom);
            cfg_bank = 6'($urandom);
            cpu_addr = 16'($urandom);
            if (n % 3 == 0) cpu_addr[15:9] = 7'b1101111;
            cpu_wr = 1'($urandom);
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule